// File: doc/BRIEF.md
# Fail-First Vector Compare Sequencer

This block runs a signed compare over a vector of register-file elements, one element per clock cycle, and writes a three-bit condition field for each element into a bank of condition registers. After producing each field it tests one chosen bit of that field. The first element whose test reports failure ends the loop and cuts the vector length short, so the length that comes out depends on the data. No later element is read or written once a failure is seen.

A caller pulses `start` with a source base index, a destination base index, two flags that mark source and destination as vector or scalar, a signed immediate, the requested length, the bit selector, the failure sense and the truncation mode. A scalar operand keeps the same index on every step. The register file sits outside the block and is read through a small combinational read port. The condition bank is also outside and is written through a one-cycle write strobe. When the loop ends, `done` pulses for one cycle and `vl_out` carries the resulting length. That length stays on the output until the next run finishes.

Top module: `ffcmp_seq`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `busy`, `done` and `cr_we` are 0 and `vl_out` is 0.
- R2: Each written field is {LT, GT, EQ}, with bit 2 = LT, bit 1 = GT and bit 0 = EQ. It comes from a signed compare of the element against `imm`, and exactly one bit is set.
- R3: At step i the read index is `src_base + i` when `src_vec` is 1 and `src_base` when it is 0. The sum wraps modulo 2^AW.
- R4: At step i the write index is `dst_base + i` when `dst_vec` is 1 and `dst_base` when it is 0. The sum wraps modulo 2^CW.
- R5: `test_sel` values 0, 1 and 2 pick field bit 0, 1 and 2 respectively, and value 3 picks a constant 0. An element fails when the picked bit equals `fail_sense`.
- R6: In inclusive mode (`incl`=1), a failure at step i writes that element's field and gives `vl_out` = i+1.
- R7: In exclusive mode (`incl`=0), a failure at step i suppresses that element's write and gives `vl_out` = i, so a failure at step 0 gives 0.
- R8: If no element fails, `vl_out` equals the requested `vl`. A request with `vl`=0 performs no writes and gives `vl_out` = 0.
- R9: Element i is handled in the (i+1)-th cycle after the `start` edge. `done` is high for exactly one cycle, in the cycle after the last handled element (the cycle after `start` when `vl`=0). `cr_we` is only high while `busy` is high.
- R10: `vl_out` changes only together with `done`. A `start` pulse while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch pulse, accepted when not busy |
| src_base | input | AW | First register-file index |
| dst_base | input | CW | First condition-register index |
| src_vec | input | 1 | Source advances per step |
| dst_vec | input | 1 | Destination advances per step |
| imm | input | DW | Signed immediate |
| vl | input | VW | Requested element count |
| test_sel | input | 2 | Field bit tested after each element |
| fail_sense | input | 1 | Bit value that counts as failure |
| incl | input | 1 | 1 keeps the failing element, 0 drops it |
| rf_addr | output | AW | Register-file read index |
| rf_data | input | DW | Register-file read data, same cycle |
| cr_we | output | 1 | Condition-register write strobe |
| cr_addr | output | CW | Condition-register write index |
| cr_field | output | 3 | Field written, {LT,GT,EQ} |
| busy | output | 1 | Loop in progress |
| done | output | 1 | One-cycle completion pulse |
| vl_out | output | VW | Resulting vector length |

## Verification
Two things can land on the same element: a test failure and the natural end of the loop. Both then compete to decide the final length and whether the last write happens. The sweep covers every length from 0 to 6 under every selector, sense, mode and scalar/vector combination, with data chosen so that failures fall on the first element, on a middle element, on the last element, or nowhere. For each run the bench compares the length, the cycle count to `done`, the number of writes and the whole condition-bank image against a model built from the requirements. An exclusive failure on the last element must give length `vl`-1 with one write fewer, and an inclusive one must give `vl`.

// File: rtl/ffcmp_pkg.sv
package ffcmp_pkg;

    typedef struct packed {
        logic lt;
        logic gt;
        logic eq;
    } crf_t;

    typedef enum logic [1:0] {
        SEL_EQ   = 2'd0,
        SEL_GT   = 2'd1,
        SEL_LT   = 2'd2,
        SEL_ZERO = 2'd3
    } tsel_e;

    function automatic crf_t cmp_field(input int a, input int b);
        crf_t f;
        f.lt = (a < b);
        f.gt = (a > b);
        f.eq = (a == b);
        return f;
    endfunction

    function automatic logic pick_bit(input crf_t f, input logic [1:0] sel);
        case (tsel_e'(sel))
            SEL_EQ:  return f.eq;
            SEL_GT:  return f.gt;
            SEL_LT:  return f.lt;
            default: return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/ffcmp_idx.sv
module ffcmp_idx #(
    parameter int IW = 4,
    parameter int SW = 4
) (
    input  logic [IW-1:0] base,
    input  logic [SW-1:0] step,
    input  logic          is_vec,
    output logic [IW-1:0] idx
);
    assign idx = base + (is_vec ? IW'(step) : '0);
endmodule

// File: rtl/ffcmp_test.sv
module ffcmp_test
    import ffcmp_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic [DW-1:0] elem,
    input  logic [DW-1:0] imm,
    input  logic [1:0]    sel,
    input  logic          sense,
    output crf_t          field,
    output logic          fail
);
    assign field = cmp_field(int'($signed(elem)), int'($signed(imm)));
    assign fail  = (pick_bit(field, sel) == sense);
endmodule

// File: rtl/ffcmp_ctl.sv
module ffcmp_ctl #(
    parameter int VW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          accept,
    input  logic [VW-1:0] vl_req,
    input  logic          fail,
    input  logic          incl,
    output logic          busy,
    output logic          done,
    output logic [VW-1:0] step,
    output logic [VW-1:0] vl_out,
    output logic          we
);
    logic [VW-1:0] vl_q;
    logic          last;

    assign last = (step == vl_q - VW'(1));
    assign we   = busy && !(fail && !incl);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy   <= 1'b0;
            done   <= 1'b0;
            step   <= '0;
            vl_q   <= '0;
            vl_out <= '0;
        end else begin
            done <= 1'b0;
            if (accept) begin
                step <= '0;
                vl_q <= vl_req;
                if (vl_req == '0) begin
                    done   <= 1'b1;
                    vl_out <= '0;
                end else begin
                    busy <= 1'b1;
                end
            end else if (busy) begin
                if (fail) begin
                    busy   <= 1'b0;
                    done   <= 1'b1;
                    vl_out <= incl ? step + VW'(1) : step;
                end else if (last) begin
                    busy   <= 1'b0;
                    done   <= 1'b1;
                    vl_out <= vl_q;
                end else begin
                    step <= step + VW'(1);
                end
            end
        end
    end
endmodule

// File: rtl/ffcmp_seq.sv
module ffcmp_seq
    import ffcmp_pkg::*;
#(
    parameter int AW = 4,
    parameter int CW = 4,
    parameter int DW = 8,
    parameter int VW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [AW-1:0] src_base,
    input  logic [CW-1:0] dst_base,
    input  logic          src_vec,
    input  logic          dst_vec,
    input  logic [DW-1:0] imm,
    input  logic [VW-1:0] vl,
    input  logic [1:0]    test_sel,
    input  logic          fail_sense,
    input  logic          incl,
    output logic [AW-1:0] rf_addr,
    input  logic [DW-1:0] rf_data,
    output logic          cr_we,
    output logic [CW-1:0] cr_addr,
    output logic [2:0]    cr_field,
    output logic          busy,
    output logic          done,
    output logic [VW-1:0] vl_out
);
    typedef struct packed {
        logic [AW-1:0] ra;
        logic [CW-1:0] ba;
        logic          sv;
        logic          dv;
        logic [DW-1:0] imm;
        logic [1:0]    sel;
        logic          sense;
        logic          incl;
    } cfg_t;

    cfg_t          cfg_q;
    logic          accept;
    logic          elem_fail;
    logic [VW-1:0] step;
    crf_t          field;

    assign accept = start && !busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (accept) begin
            cfg_q <= '{ra: src_base, ba: dst_base, sv: src_vec, dv: dst_vec,
                       imm: imm, sel: test_sel, sense: fail_sense, incl: incl};
        end
    end

    ffcmp_idx #(.IW(AW), .SW(VW)) u_src (
        .base(cfg_q.ra), .step(step), .is_vec(cfg_q.sv), .idx(rf_addr)
    );

    ffcmp_idx #(.IW(CW), .SW(VW)) u_dst (
        .base(cfg_q.ba), .step(step), .is_vec(cfg_q.dv), .idx(cr_addr)
    );

    ffcmp_test #(.DW(DW)) u_test (
        .elem(rf_data), .imm(cfg_q.imm), .sel(cfg_q.sel), .sense(cfg_q.sense),
        .field(field), .fail(elem_fail)
    );

    ffcmp_ctl #(.VW(VW)) u_ctl (
        .clk(clk), .rst(rst), .accept(accept), .vl_req(vl),
        .fail(elem_fail), .incl(cfg_q.incl),
        .busy(busy), .done(done), .step(step), .vl_out(vl_out), .we(cr_we)
    );

    assign cr_field = field;
endmodule

// File: rtl/ffcmp_chk.sv
module ffcmp_chk #(
    parameter int VW = 4
) (
    input logic          clk,
    input logic          rst,
    input logic          busy,
    input logic          done,
    input logic          cr_we,
    input logic          fail,
    input logic          incl,
    input logic [2:0]    cr_field,
    input logic [VW-1:0] vl_out
);
    logic seen;
    always_ff @(posedge clk) begin
        if (rst) seen <= 1'b0;
        else     seen <= 1'b1;
    end

    a_r9_we_only_busy: assert property (@(posedge clk) disable iff (rst)
        cr_we |-> busy);

    a_r9_done_idle: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    a_r9_end_done: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done);

    a_r10_vl_hold: assert property (@(posedge clk) disable iff (rst)
        (seen && !done) |-> $stable(vl_out));

    a_r7_drop_write: assert property (@(posedge clk) disable iff (rst)
        (busy && fail && !incl) |-> !cr_we);

    a_r2_onehot: assert property (@(posedge clk) disable iff (rst)
        cr_we |-> ($countones(cr_field) == 1));
endmodule

bind ffcmp_seq ffcmp_chk #(.VW(VW)) u_chk (
    .clk(clk), .rst(rst), .busy(busy), .done(done), .cr_we(cr_we),
    .fail(elem_fail), .incl(cfg_q.incl), .cr_field(cr_field), .vl_out(vl_out)
);

// File: tb/sim_ffcmp_seq.sv
module sim_ffcmp_seq;
    localparam int CLK_P = 10;
    localparam int AW = 4, CW = 4, DW = 8, VW = 4;

    logic clk = 0, rst = 1, start = 0;
    logic [AW-1:0] src_base = 0;
    logic [CW-1:0] dst_base = 0;
    logic src_vec = 0, dst_vec = 0, fail_sense = 0, incl = 0;
    logic [DW-1:0] imm = 0;
    logic [VW-1:0] vl = 0;
    logic [1:0] test_sel = 0;
    logic [AW-1:0] rf_addr;
    logic [DW-1:0] rf_data;
    logic cr_we, busy, done;
    logic [CW-1:0] cr_addr;
    logic [2:0] cr_field;
    logic [VW-1:0] vl_out;

    logic [DW-1:0] rf_m [16];
    logic [2:0] cr_m [16];
    logic [2:0] cr_e [16];
    int wcnt;
    int total = 0, bad = 0;

    always #(CLK_P/2) clk = ~clk;
    assign rf_data = rf_m[rf_addr];

    ffcmp_seq #(.AW(AW), .CW(CW), .DW(DW), .VW(VW)) u0 (
        .clk(clk), .rst(rst), .start(start), .src_base(src_base), .dst_base(dst_base),
        .src_vec(src_vec), .dst_vec(dst_vec), .imm(imm), .vl(vl), .test_sel(test_sel),
        .fail_sense(fail_sense), .incl(incl), .rf_addr(rf_addr), .rf_data(rf_data),
        .cr_we(cr_we), .cr_addr(cr_addr), .cr_field(cr_field), .busy(busy),
        .done(done), .vl_out(vl_out)
    );

    always @(negedge clk) begin
        if (cr_we) begin
            cr_m[cr_addr] = cr_field;
            wcnt++;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        #(CLK_P * 150000);
        bad++;
        $display("FAIL watchdog actual=hung expected=finish");
        summary();
    end

    // model from requirements
    task automatic model(output int nvl, output int nw, output int nproc);
        int a, d, t;
        logic [2:0] f;
        nvl = int'(vl); nw = 0; nproc = int'(vl);
        for (int k = 0; k < 16; k++) cr_e[k] = 3'b000;
        for (int i = 0; i < int'(vl); i++) begin
            a = (int'(src_base) + (src_vec ? i : 0)) % 16;
            d = (int'(dst_base) + (dst_vec ? i : 0)) % 16;
            f = {($signed(rf_m[a]) < $signed(imm)), ($signed(rf_m[a]) > $signed(imm)),
                 ($signed(rf_m[a]) == $signed(imm))};
            t = (test_sel == 2'd3) ? 0 : int'(f[test_sel]);
            if (t == int'(fail_sense)) begin
                nproc = i + 1;
                if (incl) begin
                    cr_e[d] = f; nw++; nvl = i + 1;
                end else begin
                    nvl = i;
                end
                return;
            end
            cr_e[d] = f; nw++;
        end
    endtask

    task automatic run_one(input int seed);
        int ev, ew, ep, cyc, same;
        string tg;
        for (int k = 0; k < 16; k++) begin
            rf_m[k] = DW'(((k * 13 + seed * 7) % 40) - 20);
            cr_m[k] = 3'b000;
        end
        wcnt = 0;
        model(ev, ew, ep);
        start = 1;
        @(negedge clk);
        start = 0;
        cyc = 1;
        while (!done && cyc < 40) begin
            @(negedge clk);
            cyc++;
        end
        tg = (ep < int'(vl)) ? (incl ? "R6 R5" : "R7 R5") :
             (ev == int'(vl) && ew == int'(vl)) ? "R8" : (incl ? "R6 R5" : "R7 R5");
        chk(tg, int'(vl_out), ev);
        chk("R9 cycles to done", cyc, ep + 1);
        chk("R6/R7 write count", wcnt, ew);
        same = 1;
        for (int k = 0; k < 16; k++) if (cr_m[k] !== cr_e[k]) same = 0;
        chk("R2 R3 R4 cr image", same, 1);
        @(negedge clk);
        chk("R9 done one cycle", int'(done), 0);
    endtask

    initial begin
        int seed, prev;
        int ims [3] = '{-5, 0, 7};
        rst = 1;
        repeat (3) @(negedge clk);
        chk("R1 busy in reset", int'(busy), 0);
        chk("R1 vl_out in reset", int'(vl_out), 0);
        rst = 0;
        @(negedge clk);
        chk("R1 done after reset", int'(done), 0);
        chk("R1 we after reset", int'(cr_we), 0);

        seed = 0;
        for (int v = 0; v <= 6; v++)
        for (int sv = 0; sv < 2; sv++)
        for (int dv = 0; dv < 2; dv++)
        for (int ic = 0; ic < 2; ic++)
        for (int sl = 0; sl < 4; sl++)
        for (int sn = 0; sn < 2; sn++)
        for (int im = 0; im < 3; im++) begin
            vl = VW'(v); src_vec = sv[0]; dst_vec = dv[0]; incl = ic[0];
            test_sel = sl[1:0]; fail_sense = sn[0]; imm = DW'(ims[im]);
            src_base = AW'(seed % 16); dst_base = CW'((seed * 5) % 16);
            run_one(seed);
            seed++;
        end

        // R10: start while busy ignored; vl_out held during run
        prev = int'(vl_out);
        vl = 6; src_vec = 1; dst_vec = 1; incl = 1; test_sel = 3; fail_sense = 1;
        src_base = 2; dst_base = 9; imm = 0;
        wcnt = 0;
        for (int k = 0; k < 16; k++) cr_m[k] = 3'b000;
        start = 1;
        @(negedge clk);
        start = 0;
        @(negedge clk);
        chk("R10 vl_out held while busy", int'(vl_out), prev);
        vl = 2; test_sel = 3; fail_sense = 0; incl = 0; start = 1;
        @(negedge clk);
        start = 0;
        begin
            int c = 3;
            while (!done && c < 40) begin @(negedge clk); c++; end
            chk("R10 restart ignored cycles", c, 7);
        end
        chk("R10 restart ignored vl", int'(vl_out), 6);
        chk("R10 restart ignored writes", wcnt, 6);
        @(negedge clk);
        summary();
    end
endmodule